// File: doc/BRIEF.md
# Indirect Branch Landing Pad Checker

This block sits beside the retirement stage of a RISC-V core and enforces forward-edge control-flow integrity. Each cycle it may see one retired instruction, along with that instruction's address and the current contents of register x7. The block decodes indirect jumps from the instruction word, in both the 32-bit JALR form and the compressed register-jump forms. Jumps through ordinary registers arm a one-bit expectation. The next instruction to retire after an armed jump must be a landing pad, which is an AUIPC that writes x0. The landing pad must sit at a word-aligned address. Its 20-bit immediate is either zero, which accepts any caller, or equal to the label that the caller placed in the upper bits of x7.

Three cases are exempt from tracking. Jumps through x1 or x5 are function returns. Jumps through x7 are software-guarded far jumps. When the expectation is not met, the block emits a one-cycle software-check exception. The exception carries a cause code, a trap value and the address of the offending instruction, and taking it drops the expectation. An enable input turns enforcement on and off. While enforcement is off, the expectation is held clear.

Top module: `lpad_cfi_guard`

## Requirements
- R1: After synchronous reset, `exc_valid` is 0 and no expectation is armed, so a plain instruction retiring first raises nothing.
- R2: A retired JALR (opcode bits [6:0] = 7'b1100111, funct3 bits [14:12] = 0) whose rs1 (bits [19:15]) is not 1, 5 or 7 arms the expectation. If the next retired instruction is not a valid landing pad, `exc_valid` pulses in the cycle after that instruction retires, with `exc_cause` = 18, `exc_tval` = 2 and `exc_pc` equal to the address of that instruction.
- R3: A jump through rs1 = 1 or rs1 = 5 does not arm the expectation.
- R4: A jump through rs1 = 7 does not arm the expectation.
- R5: A landing pad is an AUIPC (opcode 7'b0010111) with rd (bits [11:7]) = 0. Its immediate is bits [31:12]. A valid landing pad after an armed jump raises nothing and clears the expectation. An AUIPC with a nonzero rd is not a landing pad.
- R6: A landing pad whose address has bits [1:0] other than 0 does not meet an armed expectation.
- R7: A landing pad with a zero immediate is accepted whatever x7 holds.
- R8: A landing pad with a nonzero immediate is accepted only if the immediate equals x7 bits [31:12]. x7 bits [11:0] play no part.
- R9: A landing pad that retires while nothing is armed raises nothing, even if its label does not match.
- R10: While `enforce_en` is 0, no exception is raised and the expectation is cleared. An expectation armed before enforcement is dropped does not survive the period when it is off.
- R11: The exception lasts one cycle. The expectation is cleared when the exception is taken, so the instruction after the offending one raises nothing.
- R12: Cycles with `ret_valid` = 0 neither consume nor clear an armed expectation.
- R13: The compressed register jumps (bits [1:0] = 2'b10, bits [15:13] = 3'b100, bits [6:2] = 0, rs1 = bits [11:7] nonzero, bit 12 either value) are indirect jumps. The same rs1 exemptions apply to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enforce_en | input | 1 | Landing-pad enforcement enable |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_insn | input | 32 | Retired instruction word (compressed in the low half) |
| ret_pc | input | XLEN | Address of the retired instruction |
| x7_val | input | XLEN | Current contents of x7 |
| exc_valid | output | 1 | Software-check exception pulse |
| exc_cause | output | CAUSE_W | Exception cause code |
| exc_tval | output | XLEN | Exception trap value |
| exc_pc | output | XLEN | Address of the faulting instruction |

## Verification
The bench sweeps every rs1 index through both the 32-bit and the compressed jump forms. A wrong exemption set would show up as a missing exception or a spurious one on the following plain instruction. It steps the landing-pad address through all four low-bit offsets and flips each label bit in turn against x7. It also changes only the low bits of x7, which would catch a comparison against the wrong slice or a missed alignment check. Further sequences put idle cycles, enable toggles and back-to-back faults between arming and checking. These expose an expectation that leaks across a disabled period, one that is consumed by bubbles, or one that is not cleared when the exception is taken.

// File: rtl/lpad_pkg.sv
package lpad_pkg;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;
  localparam int         LABEL_W   = 20;
  localparam int         LABEL_LSB = 12;
  localparam int         NUM_EXEMPT = 3;
  // jump sources that never arm the expectation: two link registers and the guarded-jump register
  localparam logic [4:0] EXEMPT_RS1 [NUM_EXEMPT] = '{5'd1, 5'd5, 5'd7};

  typedef struct packed {
    logic               tracked_jump;
    logic               pad;
    logic [LABEL_W-1:0] pad_label;
  } dec_t;
endpackage

// File: rtl/lpad_decode.sv
module lpad_decode
  import lpad_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  logic       jalr32, jump16, ijump, exempt;
  logic [4:0] src;

  assign jalr32 = (insn[6:0] == OPC_JALR) && (insn[14:12] == 3'b000);
  assign jump16 = (insn[1:0] == 2'b10) && (insn[15:13] == 3'b100) &&
                  (insn[6:2] == 5'd0) && (insn[11:7] != 5'd0);
  assign ijump  = jalr32 || jump16;
  assign src    = jalr32 ? insn[19:15] : insn[11:7];

  always_comb begin
    exempt = 1'b0;
    for (int i = 0; i < NUM_EXEMPT; i++) begin
      if (src == EXEMPT_RS1[i]) exempt = 1'b1;
    end
  end

  always_comb begin
    dec.tracked_jump = ijump && !exempt;
    dec.pad          = (insn[6:0] == OPC_AUIPC) && (insn[11:7] == 5'd0);
    dec.pad_label    = insn[31:12];
  end
endmodule

// File: rtl/lpad_label_match.sv
module lpad_label_match
  import lpad_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [LABEL_W-1:0] pad_label,
  input  logic [XLEN-1:0]    x7_val,
  input  logic [1:0]         pc_low,
  output logic               accept
);
  logic [LABEL_W-1:0] want;
  logic               any_label;

  assign want      = x7_val[LABEL_LSB+LABEL_W-1:LABEL_LSB];
  assign any_label = (pad_label == '0);
  assign accept    = (pc_low == 2'b00) && (any_label || (pad_label == want));
endmodule

// File: rtl/lpad_track.sv
module lpad_track
  import lpad_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 6,
  parameter int CAUSE_CODE = 18,
  parameter int TVAL_CODE  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enforce_en,
  input  logic               ret_valid,
  input  logic               tracked_jump,
  input  logic               pad_ok,
  input  logic [XLEN-1:0]    ret_pc,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_tval,
  output logic [XLEN-1:0]    exc_pc
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      exc_valid <= 1'b0;
      exc_cause <= '0;
      exc_tval  <= '0;
      exc_pc    <= '0;
    end else begin
      exc_valid <= 1'b0;
      if (!enforce_en) begin
        armed <= 1'b0;
      end else if (ret_valid) begin
        if (armed) begin
          armed <= 1'b0;
          if (!pad_ok) begin
            exc_valid <= 1'b1;
            exc_cause <= CAUSE_W'(CAUSE_CODE);
            exc_tval  <= XLEN'(TVAL_CODE);
            exc_pc    <= ret_pc;
          end
        end else begin
          armed <= tracked_jump;
        end
      end
    end
  end
endmodule

// File: rtl/lpad_cfi_guard.sv
module lpad_cfi_guard
  import lpad_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 6,
  parameter int CAUSE_CODE = 18,
  parameter int TVAL_CODE  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enforce_en,
  input  logic               ret_valid,
  input  logic [31:0]        ret_insn,
  input  logic [XLEN-1:0]    ret_pc,
  input  logic [XLEN-1:0]    x7_val,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_tval,
  output logic [XLEN-1:0]    exc_pc
);
  dec_t dec;
  logic label_ok;
  logic unused_x7;

  assign unused_x7 = ^x7_val;

  lpad_decode u_dec (
    .insn (ret_insn),
    .dec  (dec)
  );

  lpad_label_match #(.XLEN(XLEN)) u_match (
    .pad_label (dec.pad_label),
    .x7_val    (x7_val),
    .pc_low    (ret_pc[1:0]),
    .accept    (label_ok)
  );

  lpad_track #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W),
    .CAUSE_CODE(CAUSE_CODE), .TVAL_CODE(TVAL_CODE)
  ) u_track (
    .clk          (clk),
    .rst          (rst),
    .enforce_en   (enforce_en),
    .ret_valid    (ret_valid),
    .tracked_jump (dec.tracked_jump),
    .pad_ok       (dec.pad && label_ok),
    .ret_pc       (ret_pc),
    .exc_valid    (exc_valid),
    .exc_cause    (exc_cause),
    .exc_tval     (exc_tval),
    .exc_pc       (exc_pc)
  );
endmodule

// File: rtl/lpad_cfi_guard_chk.sv
module lpad_cfi_guard_chk #(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 6,
  parameter int CAUSE_CODE = 18,
  parameter int TVAL_CODE  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               enforce_en,
  input logic               ret_valid,
  input logic [XLEN-1:0]    ret_pc,
  input logic               exc_valid,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic [XLEN-1:0]    exc_tval,
  input logic [XLEN-1:0]    exc_pc
);
  p_cause_tval_r2: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_cause == CAUSE_W'(CAUSE_CODE)) && (exc_tval == XLEN'(TVAL_CODE)));

  p_fault_pc_r2: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_pc == $past(ret_pc)));

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> !exc_valid);

  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !enforce_en |=> !exc_valid);

  p_bubble_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !ret_valid |=> !exc_valid);
endmodule

bind lpad_cfi_guard lpad_cfi_guard_chk #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .CAUSE_CODE(CAUSE_CODE), .TVAL_CODE(TVAL_CODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enforce_en (enforce_en),
  .ret_valid  (ret_valid),
  .ret_pc     (ret_pc),
  .exc_valid  (exc_valid),
  .exc_cause  (exc_cause),
  .exc_tval   (exc_tval),
  .exc_pc     (exc_pc)
);

// File: tb/tb_lpad_cfi_guard.sv
`timescale 1ns/1ps
module tb_lpad_cfi_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enforce_en = 1'b1;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_insn = '0;
  logic [31:0] ret_pc = '0;
  logic [31:0] x7_val = '0;
  logic        exc_valid;
  logic [5:0]  exc_cause;
  logic [31:0] exc_tval;
  logic [31:0] exc_pc;

  int total = 0;
  int bad = 0;
  logic [31:0] pc = 32'h0000_1000;

  localparam logic [31:0] NOP = 32'h0000_0013;

  always #5 clk = ~clk;

  lpad_cfi_guard dut (
    .clk(clk), .rst(rst), .enforce_en(enforce_en), .ret_valid(ret_valid),
    .ret_insn(ret_insn), .ret_pc(ret_pc), .x7_val(x7_val),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval), .exc_pc(exc_pc)
  );

  function automatic logic [31:0] jalr(input logic [4:0] rs1);
    return {12'h000, rs1, 3'b000, 5'd1, 7'b1100111};
  endfunction
  function automatic logic [31:0] cjump(input logic [4:0] rs1, input logic link);
    return {16'h0000, 3'b100, link, rs1, 5'd0, 2'b10};
  endfunction
  function automatic logic [31:0] auipc(input logic [4:0] rd, input logic [19:0] imm);
    return {imm, rd, 7'b0010111};
  endfunction

  // drive at the falling edge, sample one time unit after the rising edge
  task automatic step(input logic v, input logic [31:0] insn, input logic [31:0] at,
                      input logic [31:0] x7, input logic exp, input string tag);
    @(negedge clk);
    ret_valid = v; ret_insn = insn; ret_pc = at; x7_val = x7;
    @(posedge clk); #1;
    total++;
    if (exc_valid !== exp ||
        (exp && (exc_cause !== 6'd18 || exc_tval !== 32'd2 || exc_pc !== at))) begin
      bad++;
      $display("FAIL %s: valid=%0b cause=%0d tval=%0d pc=%h expected valid=%0b cause=18 tval=2 pc=%h",
               tag, exc_valid, exc_cause, exc_tval, exc_pc, exp, at);
    end
    pc = pc + 4;
  endtask

  task automatic idle(input logic exp, input string tag);
    step(1'b0, NOP, pc, 32'h0, exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    total++;
    if (exc_valid !== 1'b0) begin
      bad++; $display("FAIL R1: exc_valid=%0b expected 0", exc_valid);
    end
    step(1'b1, NOP, pc, 32'h0, 1'b0, "R1 plain after reset");

    // R2/R3/R4: every rs1 through 32-bit JALR
    for (int r = 0; r < 32; r++) begin
      logic trk;
      trk = !(r == 1 || r == 5 || r == 7);
      step(1'b1, jalr(5'(r)), pc, 32'h0, 1'b0, "R2 jalr retire");
      step(1'b1, NOP, pc, 32'h0, trk, (r == 7) ? "R4 x7 exempt" :
           (r == 1 || r == 5) ? "R3 link exempt" : "R2 tracked jalr");
    end

    // R13: compressed jumps, both link variants
    for (int r = 1; r < 32; r++) begin
      for (int l = 0; l < 2; l++) begin
        logic trk;
        trk = !(r == 1 || r == 5 || r == 7);
        step(1'b1, cjump(5'(r), 1'(l)), pc, 32'h0, 1'b0, "R13 cjump retire");
        step(1'b1, NOP, pc, 32'h0, trk, "R13 compressed jump");
      end
    end

    // R5: valid pad clears; AUIPC with rd != 0 is not a pad
    step(1'b1, jalr(5'd10), pc, 32'h0, 1'b0, "R5 arm");
    step(1'b1, auipc(5'd0, 20'h12345), pc, 32'h1234_5ABC, 1'b0, "R5 valid pad");
    step(1'b1, NOP, pc, 32'h0, 1'b0, "R5 cleared after pad");
    step(1'b1, jalr(5'd10), pc, 32'h0, 1'b0, "R5 arm");
    step(1'b1, auipc(5'd3, 20'h0), pc, 32'h0, 1'b1, "R5 auipc rd3 not pad");

    // R6: address offsets
    for (int o = 0; o < 4; o++) begin
      step(1'b1, jalr(5'd11), pc, 32'h0, 1'b0, "R6 arm");
      step(1'b1, auipc(5'd0, 20'h0), pc + 32'(o), 32'h0, (o != 0), "R6 pad alignment");
    end

    // R7: zero label accepts any x7
    for (int k = 0; k < 8; k++) begin
      step(1'b1, jalr(5'd12), pc, 32'h0, 1'b0, "R7 arm");
      step(1'b1, auipc(5'd0, 20'h0), pc, 32'h9E37_79B9 * 32'(k + 1), 1'b0, "R7 zero label");
    end

    // R8: label bit flips and low-bit independence
    begin
      logic [19:0] lbl;
      lbl = 20'hA5C3E;
      for (int b = 0; b < 20; b++) begin
        step(1'b1, jalr(5'd13), pc, 32'h0, 1'b0, "R8 arm");
        step(1'b1, auipc(5'd0, lbl), pc, {lbl ^ (20'h1 << b), 12'h000}, 1'b1, "R8 label mismatch");
      end
      for (int b = 0; b < 12; b++) begin
        step(1'b1, jalr(5'd13), pc, 32'h0, 1'b0, "R8 arm");
        step(1'b1, auipc(5'd0, lbl), pc, {lbl, 12'h1 << b}, 1'b0, "R8 low x7 ignored");
      end
    end

    // R9: unarmed pad with wrong label
    step(1'b1, auipc(5'd0, 20'h00042), pc, 32'h0000_0000, 1'b0, "R9 unarmed pad");
    step(1'b1, auipc(5'd0, 20'h00042), pc + 2, 32'h0000_0000, 1'b0, "R9 unarmed misaligned pad");

    // R10: disabled enforcement
    enforce_en = 1'b0;
    step(1'b1, jalr(5'd10), pc, 32'h0, 1'b0, "R10 jump while disabled");
    step(1'b1, NOP, pc, 32'h0, 1'b0, "R10 no exception while disabled");
    enforce_en = 1'b1;
    step(1'b1, jalr(5'd10), pc, 32'h0, 1'b0, "R10 arm");
    enforce_en = 1'b0;
    idle(1'b0, "R10 disabled idle");
    enforce_en = 1'b1;
    step(1'b1, NOP, pc, 32'h0, 1'b0, "R10 expectation dropped");

    // R11: pulse length and clear on exception
    step(1'b1, jalr(5'd20), pc, 32'h0, 1'b0, "R11 arm");
    step(1'b1, NOP, pc, 32'h0, 1'b1, "R11 fault");
    step(1'b1, NOP, pc, 32'h0, 1'b0, "R11 single pulse and cleared");

    // R12: bubbles between jump and next retirement
    step(1'b1, jalr(5'd21), pc, 32'h0, 1'b0, "R12 arm");
    idle(1'b0, "R12 bubble");
    idle(1'b0, "R12 bubble");
    idle(1'b0, "R12 bubble");
    step(1'b1, NOP, pc, 32'h0, 1'b1, "R12 expectation survives bubbles");
    step(1'b1, jalr(5'd21), pc, 32'h0, 1'b0, "R12 arm");
    idle(1'b0, "R12 bubble");
    step(1'b1, auipc(5'd0, 20'h0), pc, 32'h0, 1'b0, "R12 pad after bubble");
    step(1'b1, NOP, pc, 32'h0, 1'b0, "R12 cleared");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule